// File: doc/BRIEF.md
# Register-Move and Accumulator-ALU Opcode Executor

This block executes one single-byte opcode at a time for an 8-bit accumulator core. The supported range is 0x40 to 0xBF. It holds the accumulator A, six general registers (B, C, D, E, H, L) and an 8-bit flag register. Opcodes 0x40 to 0x7F copy a byte between registers, or between a register and the memory byte whose address is the pair H:L. Opcodes 0x80 to 0xBF apply one of eight arithmetic or logic operations to A and write the flags. The code 0x76 sits where a memory-to-memory copy would be. It is taken as a halt request instead.

A sequencer pulses `start_i` with the opcode on `opcode_i` and waits for `done_o`. A memory operand is read through a request/data port that returns its byte in the same cycle as the request. A memory destination is written through the same port. The register file and flags are visible at the ports for the surrounding core.

Top module: `opexec_core`

## Requirements
- R1: While reset is asserted, and right after it is released, every register slot and `flags_o` read 0, and `halted_o`, `done_o` and `mem_req_o` are 0.
- R2: Opcodes 0x40 to 0x7F (except 0x76) copy the operand selected by bits 2:0 into the target selected by bits 5:3. The 3-bit codes are B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7. Register code k appears on `regs_o[8k+7:8k]`, and slot 6 always reads 0.
- R3: Operand code 6 as a source gives exactly one read request (`mem_req_o`=1, `mem_we_o`=0) at address {H,L}, and `mem_rdata_i` is sampled in that cycle. Code 6 as a target gives one write request at {H,L} carrying the operand on `mem_wdata_o`. A register-source opcode makes no read request.
- R4: Opcodes 0x40 to 0x7F leave `flags_o` unchanged.
- R5: Opcodes 0x80 to 0xBF take their operand from bits 2:0 (same codes as R2). Bits 5:3 select the operation: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP. The 8-bit result goes to A.
- R6: `flags_o` bits 7..0 are S, Z, Y, H, X, P/V, N, C. S is result bit 7, Z is set when the result is zero, Y is result bit 5 and X is result bit 3.
- R7: ADD and ADC (which adds C) clear N. H is the carry out of bit 3, C is the carry out of bit 7, and P/V is signed overflow.
- R8: SUB and SBC (which also subtracts C) set N. H is the borrow from bit 4, C is the borrow from bit 8, and P/V is signed overflow.
- R9: AND sets H and clears N and C. XOR and OR clear H, N and C. For all three, P/V is 1 when the result has an even number of one bits.
- R10: CP sets the flags as SUB would, except that Y and X come from operand bits 5 and 3. A is left unchanged.
- R11: Opcode 0x76 writes no register, flag or memory byte. It pulses `done_o` one cycle after the start edge and raises `halted_o`. `halted_o` stays high, and every later start is ignored, until reset.
- R12: `done_o` is high for exactly one cycle. It follows the start edge by 2 cycles for a register operand and by 3 for a memory operand. A start while busy is ignored, and so is a start whose opcode lies outside 0x40 to 0xBF (no done, no change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opcode start strobe |
| opcode_i | input | 8 | Opcode sampled with the start strobe |
| mem_rdata_i | input | DATA_W | Memory read byte, valid in the request cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 2*DATA_W | Address {H,L} |
| mem_wdata_o | output | DATA_W | Write byte |
| done_o | output | 1 | One-cycle completion pulse |
| halted_o | output | 1 | Sticky halt state |
| regs_o | output | 8*DATA_W | Register slots by code |
| flags_o | output | 8 | Flag register S Z Y H X P/V N C |

## Verification
The hardest state to reach from the ports is a carry-consuming ADC or SBC with a known carry-in and known operands. C is written only by an ALU opcode, and registers can only be loaded through memory reads at H:L. The sweep therefore loads B once, then for each operation reloads A through memory and runs the opcode. Because loads never touch flags, each ADC or SBC inherits the carry left by the ADD or SUB just before it. The sticky halt is reached last, since only reset leaves it.

// File: rtl/opexec_pkg.sv
package opexec_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  localparam logic [CODE_W-1:0] CODE_H   = 3'd4;
  localparam logic [CODE_W-1:0] CODE_L   = 3'd5;
  localparam logic [CODE_W-1:0] CODE_MEM = 3'd6;
  localparam logic [CODE_W-1:0] CODE_A   = 3'd7;

  localparam logic [7:0] OP_HALT = 8'h76;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_ADC, ALU_SUB, ALU_SBC, ALU_AND, ALU_XOR, ALU_OR, ALU_CP
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_DONE
  } exec_state_e;
endpackage

// File: rtl/opexec_regfile.sv
module opexec_regfile
  import opexec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [CODE_W-1:0]        wr_code_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     flags_we_i,
  input  logic [7:0]               flags_d_i,
  input  logic [CODE_W-1:0]        rd_code_i,
  output logic [DW-1:0]            rd_data_o,
  output logic [2*DW-1:0]          hl_o,
  output logic [DW-1:0]            acc_o,
  output logic [NUM_CODES*DW-1:0]  regs_o,
  output logic [7:0]               flags_o
);
  logic [DW-1:0] slot [NUM_CODES];
  logic [7:0]    flags_q;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_slot
    if (i == int'(CODE_MEM)) begin : g_hole
      assign slot[i] = '0;
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (wr_en_i && wr_code_i == CODE_W'(i))  q <= wr_data_i;
      end
      assign slot[i] = q;
    end
    assign regs_o[i*DW +: DW] = slot[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (flags_we_i) flags_q <= flags_d_i;
  end

  assign rd_data_o = slot[rd_code_i];
  assign hl_o      = {slot[CODE_H], slot[CODE_L]};
  assign acc_o     = slot[CODE_A];
  assign flags_o   = flags_q;
endmodule

// File: rtl/opexec_alu.sv
module opexec_alu
  import opexec_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e        op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           cin_i,
  output logic [DW-1:0]  res_o,
  output logic [7:0]     flags_o,
  output logic           wr_acc_o
);
  localparam int MSB = DW - 1;

  logic          ci, is_logic;
  logic [DW:0]   sum, dif;
  logic [DW-1:0] res;
  logic          fh, fv, fn, fc, fy, fx, fp;

  always_comb begin
    ci       = (op_i == ALU_ADC || op_i == ALU_SBC) ? cin_i : 1'b0;
    sum      = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, ci};
    dif      = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, ci};
    res      = sum[DW-1:0];
    fh       = 1'b0;
    fv       = 1'b0;
    fn       = 1'b0;
    fc       = 1'b0;
    is_logic = 1'b0;
    case (op_i)
      ALU_ADD, ALU_ADC: begin
        res = sum[DW-1:0];
        fc  = sum[DW];
        fh  = a_i[4] ^ b_i[4] ^ sum[4];   // carry into bit 4
        fv  = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      ALU_SUB, ALU_SBC, ALU_CP: begin
        res = dif[DW-1:0];
        fc  = dif[DW];
        fh  = a_i[4] ^ b_i[4] ^ dif[4];   // borrow into bit 4
        fv  = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);
        fn  = 1'b1;
      end
      ALU_AND: begin res = a_i & b_i; fh = 1'b1; is_logic = 1'b1; end
      ALU_XOR: begin res = a_i ^ b_i; is_logic = 1'b1; end
      ALU_OR:  begin res = a_i | b_i; is_logic = 1'b1; end
      default: ;
    endcase
    fp = is_logic ? ~^res : fv;
    fy = (op_i == ALU_CP) ? b_i[5] : res[5];
    fx = (op_i == ALU_CP) ? b_i[3] : res[3];
  end

  assign res_o    = res;
  assign flags_o  = {res[MSB], res == '0, fy, fh, fx, fp, fn, fc};
  assign wr_acc_o = (op_i != ALU_CP);
endmodule

// File: rtl/opexec_ctrl.sv
module opexec_ctrl
  import opexec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         opcode_i,
  input  logic [DW-1:0]      rd_data_i,
  input  logic [2*DW-1:0]    hl_i,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic [DW-1:0]      alu_res_i,
  input  logic [7:0]         alu_flags_i,
  input  logic               alu_wr_acc_i,
  output logic [CODE_W-1:0]  rd_code_o,
  output alu_op_e            alu_op_o,
  output logic [DW-1:0]      alu_b_o,
  output logic               wr_en_o,
  output logic [CODE_W-1:0]  wr_code_o,
  output logic [DW-1:0]      wr_data_o,
  output logic               flags_we_o,
  output logic [7:0]         flags_d_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [2*DW-1:0]    mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               done_o,
  output logic               halted_o
);
  exec_state_e       state_q;
  logic              halted_q, is_alu_q;
  logic [CODE_W-1:0] src_q, dst_q;
  logic [DW-1:0]     opnd_q, operand;
  logic              accept, in_range, exec, st_mem;

  assign in_range = opcode_i[7] ^ opcode_i[6];
  assign accept   = (state_q == ST_IDLE) && start_i && !halted_q && in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      halted_q <= 1'b0;
      is_alu_q <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      opnd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          is_alu_q <= opcode_i[7];
          dst_q    <= opcode_i[5:3];
          src_q    <= opcode_i[2:0];
          if (opcode_i == OP_HALT) begin
            halted_q <= 1'b1;
            state_q  <= ST_DONE;
          end else if (opcode_i[2:0] == CODE_MEM) begin
            state_q  <= ST_FETCH;
          end else begin
            state_q  <= ST_EXEC;
          end
        end
        ST_FETCH: begin
          opnd_q  <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign exec    = (state_q == ST_EXEC);
  assign operand = (src_q == CODE_MEM) ? opnd_q : rd_data_i;
  assign st_mem  = exec && !is_alu_q && (dst_q == CODE_MEM);

  always_comb begin
    wr_en_o    = 1'b0;
    wr_code_o  = dst_q;
    wr_data_o  = operand;
    flags_we_o = 1'b0;
    if (exec) begin
      if (is_alu_q) begin
        flags_we_o = 1'b1;
        wr_en_o    = alu_wr_acc_i;
        wr_code_o  = CODE_A;
        wr_data_o  = alu_res_i;
      end else begin
        wr_en_o    = (dst_q != CODE_MEM);
      end
    end
  end

  assign rd_code_o   = src_q;
  assign alu_op_o    = alu_op_e'(dst_q);
  assign alu_b_o     = operand;
  assign flags_d_o   = alu_flags_i;
  assign mem_req_o   = (state_q == ST_FETCH) || st_mem;
  assign mem_we_o    = st_mem;
  assign mem_addr_o  = hl_i;
  assign mem_wdata_o = operand;
  assign done_o      = (state_q == ST_DONE);
  assign halted_o    = halted_q;
endmodule

// File: rtl/opexec_core.sv
module opexec_core
  import opexec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [7:0]                  opcode_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [2*DATA_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  output logic                        done_o,
  output logic                        halted_o,
  output logic [NUM_CODES*DATA_W-1:0] regs_o,
  output logic [7:0]                  flags_o
);
  logic [CODE_W-1:0]   rd_code, wr_code;
  logic [DATA_W-1:0]   rd_data, acc, alu_b, alu_res, wr_data;
  logic [2*DATA_W-1:0] hl;
  logic [7:0]          alu_flags, flags_d;
  logic                wr_en, flags_we, alu_wr_acc;
  alu_op_e             alu_op;

  opexec_regfile #(.DW(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_code_i  (wr_code),
    .wr_data_i  (wr_data),
    .flags_we_i (flags_we),
    .flags_d_i  (flags_d),
    .rd_code_i  (rd_code),
    .rd_data_o  (rd_data),
    .hl_o       (hl),
    .acc_o      (acc),
    .regs_o     (regs_o),
    .flags_o    (flags_o)
  );

  opexec_alu #(.DW(DATA_W)) u_alu (
    .op_i     (alu_op),
    .a_i      (acc),
    .b_i      (alu_b),
    .cin_i    (flags_o[0]),
    .res_o    (alu_res),
    .flags_o  (alu_flags),
    .wr_acc_o (alu_wr_acc)
  );

  opexec_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .opcode_i     (opcode_i),
    .rd_data_i    (rd_data),
    .hl_i         (hl),
    .mem_rdata_i  (mem_rdata_i),
    .alu_res_i    (alu_res),
    .alu_flags_i  (alu_flags),
    .alu_wr_acc_i (alu_wr_acc),
    .rd_code_o    (rd_code),
    .alu_op_o     (alu_op),
    .alu_b_o      (alu_b),
    .wr_en_o      (wr_en),
    .wr_code_o    (wr_code),
    .wr_data_o    (wr_data),
    .flags_we_o   (flags_we),
    .flags_d_o    (flags_d),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .done_o       (done_o),
    .halted_o     (halted_o)
  );
endmodule

// File: rtl/opexec_checks.sv
module opexec_checks
  import opexec_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [7:0]              opcode_i,
  input logic                    mem_req_o,
  input logic                    mem_we_o,
  input logic [2*DW-1:0]         mem_addr_o,
  input logic                    done_o,
  input logic                    halted_o,
  input logic [NUM_CODES*DW-1:0] regs_o,
  input logic [7:0]              flags_o
);
  logic          trk_busy, trk_load, trk_cp, trk_memsrc;
  logic [7:0]    f_snap;
  logic [DW-1:0] a_snap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_busy   <= 1'b0;
      trk_load   <= 1'b0;
      trk_cp     <= 1'b0;
      trk_memsrc <= 1'b0;
      f_snap     <= '0;
      a_snap     <= '0;
    end else if (done_o) begin
      trk_busy <= 1'b0;
    end else if (start_i && !trk_busy && !halted_o && (opcode_i[7] ^ opcode_i[6])) begin
      trk_busy   <= 1'b1;
      trk_load   <= (opcode_i[7:6] == 2'b01);
      trk_cp     <= (opcode_i[7:3] == 5'b10111);
      trk_memsrc <= (opcode_i[2:0] == CODE_MEM);
      f_snap     <= flags_o;
      a_snap     <= regs_o[int'(CODE_A)*DW +: DW];
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_we_with_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  assert_addr_is_hl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == {regs_o[int'(CODE_H)*DW +: DW], regs_o[int'(CODE_L)*DW +: DW]});

  assert_regsrc_no_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_busy && !trk_memsrc && mem_req_o) |-> mem_we_o);

  assert_load_keeps_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trk_busy && trk_load) |-> flags_o == f_snap);

  assert_cp_keeps_acc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trk_busy && trk_cp) |-> regs_o[int'(CODE_A)*DW +: DW] == a_snap);

  assert_halt_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(regs_o) && $stable(flags_o) && !mem_req_o));
endmodule

bind opexec_core opexec_checks #(.DW(DATA_W)) u_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .opcode_i   (opcode_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .halted_o   (halted_o),
  .regs_o     (regs_o),
  .flags_o    (flags_o)
);

// File: tb/tb_opexec_core.sv
module tb_opexec_core;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    opcode_i = 8'h00;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          mem_req_o, mem_we_o, done_o, halted_o;
  logic [2*DW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [8*DW-1:0] regs_o;
  logic [7:0]    flags_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  opexec_core #(.DATA_W(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
    .mem_rdata_i(mem_rdata_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .done_o(done_o),
    .halted_o(halted_o), .regs_o(regs_o), .flags_o(flags_o)
  );

  int checks = 0;
  int errors = 0;
  int m_r[8];
  int m_f;
  bit exp_wr;
  int exp_wdata;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr;
  endfunction

  task automatic check_state(string req);
    int bad = -1;
    int act = 0;
    int exp = 0;
    for (int i = 0; i < 8; i++) begin
      int e = (i == 6) ? 0 : m_r[i];
      if (int'(regs_o[i*8 +: 8]) != e && bad < 0) begin
        bad = i; act = int'(regs_o[i*8 +: 8]); exp = e;
      end
    end
    if (bad >= 0) chk(1'b0, req, $sformatf("register code %0d", bad), act, exp);
    else chk(int'(flags_o) == m_f, req, "flags", int'(flags_o), m_f);
  endtask

  // expected effect of one opcode, from the requirements
  task automatic model(logic [7:0] op, int mem);
    int s = op[2:0];
    int d = op[5:3];
    int b = (s == 6) ? mem : m_r[s];
    int a = m_r[7];
    int c = m_f & 1;
    int r, ci, h, v, n, cy, p, y, x;
    exp_wr = 1'b0;
    if (op == 8'h76) return;
    if (op[7:6] == 2'b01) begin
      if (d == 6) begin exp_wr = 1'b1; exp_wdata = b; end
      else m_r[d] = b;
      return;
    end
    h = 0; v = 0; n = 0; cy = 0;
    case (d)
      0, 1: begin
        ci = (d == 1) ? c : 0;
        r = a + b + ci;
        cy = (r > 255) ? 1 : 0;
        h = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
        r = r & 255;
        v = (((a ^ b) & 128) == 0 && ((a ^ r) & 128) != 0) ? 1 : 0;
      end
      2, 3, 7: begin
        ci = (d == 3) ? c : 0;
        r = a - b - ci;
        cy = (r < 0) ? 1 : 0;
        h = (((a & 15) - (b & 15) - ci) < 0) ? 1 : 0;
        r = r & 255;
        v = (((a ^ b) & 128) != 0 && ((a ^ r) & 128) != 0) ? 1 : 0;
        n = 1;
      end
      4: begin r = a & b; h = 1; end
      5: r = a ^ b;
      default: r = a | b;
    endcase
    if (d >= 4 && d <= 6) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
      p = (ones % 2 == 0) ? 1 : 0;
    end else p = v;
    y = (d == 7) ? ((b >> 5) & 1) : ((r >> 5) & 1);
    x = (d == 7) ? ((b >> 3) & 1) : ((r >> 3) & 1);
    m_f = (((r >> 7) & 1) << 7) | ((r == 0 ? 1 : 0) << 6) | (y << 5) | (h << 4) |
          (x << 3) | (p << 2) | (n << 1) | cy;
    if (d != 7) m_r[7] = r;
  endtask

  task automatic run_op(logic [7:0] op, logic [7:0] mem, bit poke, string req);
    int n = 0;
    bit saw_rd = 0;
    bit saw_wr = 0;
    int wd = 0;
    int addr_exp = m_r[4] * 256 + m_r[5];
    int exp_n = (op == 8'h76) ? 1 : ((op[2:0] == 3'd6) ? 3 : 2);
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = op; mem_rdata_i = mem;
    @(negedge clk_i);
    n = 1;
    start_i = poke;               // second start while busy must be dropped
    if (poke) opcode_i = 8'h80;
    forever begin
      if (done_o) break;
      if (mem_req_o) begin
        chk(int'(mem_addr_o) == addr_exp, "R3", "memory address", int'(mem_addr_o), addr_exp);
        if (mem_we_o) begin saw_wr = 1; wd = int'(mem_wdata_o); end
        else saw_rd = 1;
      end
      if (n >= 20) break;
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
    end
    start_i = 1'b0;
    model(op, int'(mem));
    chk(n == exp_n, "R12", $sformatf("done latency op %0h", op), n, exp_n);
    chk(saw_rd == ((op[2:0] == 3'd6) && op != 8'h76), "R3",
        $sformatf("read request op %0h", op), saw_rd, (op[2:0] == 3'd6) && op != 8'h76);
    chk(saw_wr == exp_wr, "R3", $sformatf("write request op %0h", op), saw_wr, exp_wr);
    if (exp_wr && saw_wr) chk(wd == exp_wdata, "R3", "write data", wd, exp_wdata);
    check_state($sformatf("%s op %0h", req, op));
    @(negedge clk_i);
    chk(!done_o, "R12", "done width", done_o, 0);
  endtask

  task automatic idle_probe(logic [7:0] op, string req);
    int seen = 0;
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = op;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) begin
      if (done_o || mem_req_o) seen = 1;
      @(negedge clk_i);
    end
    chk(seen == 0, req, $sformatf("activity after ignored start %0h", op), seen, 0);
    check_state(req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) m_r[i] = 0;
    m_f = 0;
    repeat (2) @(negedge clk_i);
    chk(regs_o == '0 && flags_o == 8'h00, "R1", "state in reset", int'(flags_o), 0);
    chk(!halted_o && !done_o && !mem_req_o, "R1", "controls in reset",
        {halted_o, done_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!halted_o && !done_o && !mem_req_o, "R1", "controls after reset",
        {halted_o, done_o, mem_req_o}, 0);
    check_state("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] blist [12] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80,
                               8'h81, 8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h08};
    string tag [8] = '{"R5 R6 R7 add", "R5 R6 R7 adc", "R5 R6 R8 sub", "R5 R6 R8 sbc",
                       "R5 R6 R9 and", "R5 R6 R9 xor", "R5 R6 R9 or", "R5 R6 R10 cp"};
    do_reset();

    // every load opcode, twice, with fresh memory bytes (R2 R3 R4)
    for (int rep = 0; rep < 2; rep++)
      for (int d = 0; d < 8; d++)
        for (int s = 0; s < 8; s++) begin
          logic [7:0] op = 8'h40 | 8'(d << 3) | 8'(s);
          if (op != 8'h76) run_op(op, rnd(), 1'b0, "R2 R4");
        end

    // accumulator sweep: B fixed, A reloaded before each operation
    for (int a = 0; a < 256; a += 3)
      for (int bi = 0; bi < 12; bi++) begin
        run_op(8'h46, blist[bi], 1'b0, "R2 R3");
        for (int o = 0; o < 8; o++) begin
          run_op(8'h7E, 8'(a), 1'b0, "R2 R3");
          run_op(8'h80 | 8'(o << 3), 8'h00, 1'b0, tag[o]);
        end
      end

    // every ALU opcode including memory and A operands
    for (int rep = 0; rep < 4; rep++)
      for (int o = 0; o < 64; o++) begin
        logic [7:0] ld = 8'h40 | (rnd() & 8'h3F);
        if (ld == 8'h76) ld = 8'h77;
        run_op(ld, rnd(), 1'b0, "R2");
        run_op(8'h80 | 8'(o), rnd(), 1'b0, tag[o >> 3]);
      end

    // start while busy (R12)
    run_op(8'h48, 8'h00, 1'b1, "R12 busy start");
    run_op(8'h86, 8'h3C, 1'b1, "R12 busy start");

    // opcodes outside the range (R12)
    idle_probe(8'h3E, "R12 out of range");
    idle_probe(8'hC6, "R12 out of range");
    idle_probe(8'h00, "R12 out of range");

    // halt (R11)
    run_op(8'h76, 8'h99, 1'b0, "R11 halt");
    chk(halted_o, "R11", "halted raised", halted_o, 1);
    idle_probe(8'h7E, "R11 start while halted");
    idle_probe(8'h80, "R11 start while halted");
    chk(halted_o, "R11", "halted held", halted_o, 1);

    do_reset();
    run_op(8'h7E, 8'h21, 1'b0, "R1 R2 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule